// File: doc/BRIEF.md
# Serial ADC Interface Responder

This block stands in for the digital side of a serial analog-to-digital converter so that a host controller's serial driver and polling logic can be exercised in simulation or on a prototype. The host lowers chip select, toggles a serial clock, and sends an 8-bit instruction on the data input. During the same transfer the block shifts a word out on the data output. That word is either the result of an earlier conversion or the status word. No analog behaviour is modelled. Conversion results are taken from a parallel sample input at the moment a simulated conversion finishes.

Calibration, power-up and conversion each take a fixed number of clock cycles, and these counts are parameters. An end-of-conversion output lets the host wait for results. The length of each output word, whether it carries a sign bit, and its bit order all depend on the format chosen when that conversion was started. The output is therefore always one transfer behind the instruction that produced it.

The serial pins are sampled in the block's own clock domain. The serial clock must run well below the system clock; at least four system clocks per serial clock phase.

Top module: `adc_rsp`

## Requirements
- R1: After reset, end of conversion is high and the data output is low. The configuration is 12-bit width, sign included, MSB first and acquisition select 01 (10 cycles).
- R2: An instruction is the first 8 data-input bits of a transfer, MSB first, each taken on a rising serial clock edge after chip select falls. Opcode instr[7:5] selects the action: 000 sets sign inclusion to instr[0]; 001 sets acquisition select to instr[1:0]; 010 starts a conversion, with instr[1:0] giving width (00 = 8, 01 = 12, 1x = 16) and instr[2] = 1 meaning LSB first; 011 requests status; 100 starts calibration; all other opcodes do nothing.
- R3: The first instruction after reset starts calibration and is otherwise discarded. While calibration runs, any transfer that is not a status read shifts out all zeros.
- R4: After a status-request instruction, the next transfer shifts out the 9-bit status word, bit 8 first. The bits are: bit 0 power-up in progress, bit 1 power-down in progress (always 0), bit 2 calibration in progress, bit 3 width 8, bit 4 width 12, bit 5 width 16, bit 6 sign included, bit 7 LSB first, bit 8 test mode (always 0).
- R5: A conversion instruction drops end of conversion one cycle after it is decoded. End of conversion stays low for exactly acquisition time plus CONV_CYCLES cycles, then rises as the result is stored.
- R6: Acquisition select 00, 01, 10 and 11 give 6, 10, 18 and 34 cycles.
- R7: A result word is the top W bits of sample[15:0], where W is the width. When sign is included, sample[16] is added above them, giving 9, 13 or 17 bits. The whole word is sent MSB first, or fully reversed when LSB first.
- R8: Sign and acquisition instructions start no conversion. The transfer that follows them shifts out the same stored result again.
- R9: If chip select falls while a conversion runs, the conversion is aborted. End of conversion rises and the stored result is unchanged.
- R10: A conversion instruction received while calibration runs is ignored.
- R11: The first output bit appears after chip select falls, and the next bit after each falling serial clock edge. The data output is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial instruction input |
| sample | input | 17 | Sign (bit 16) and 16-bit magnitude captured at conversion end |
| do_o | output | 1 | Serial data output |
| eoc | output | 1 | End of conversion, low while converting |

## Verification
The bench walks through a host session:
- Calibration is started, and status is polled both while calibration runs and after it ends. This separates the busy and idle status images and shows that the zero word is output during calibration.
- Conversions are then run in three variants: 8-bit with sign and MSB first, 16-bit without sign and LSB first, and a conversion that is aborted. The sample patterns are asymmetric, so a wrong width, a missing or misplaced sign bit, or an unreversed word gives a different value.
- Two acquisition settings are used, with different conversion lengths, so that timing errors and ignored selects show up.
- Configuration-only transfers and a conversion instruction sent during calibration confirm that the stored result and end of conversion are left alone.

// File: rtl/adc_rsp_pkg.sv
package adc_rsp_pkg;

    localparam int WORD_W = 17;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        OP_SIGN   = 3'b000,
        OP_ACQ    = 3'b001,
        OP_CONV   = 3'b010,
        OP_STATUS = 3'b011,
        OP_CAL    = 3'b100
    } op_e;

    function automatic int width_of(input logic [1:0] fmt);
        if (fmt[1])      return 16;
        else if (fmt[0]) return 12;
        else             return 8;
    endfunction

    function automatic int acq_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 6;
            2'b01:   return 10;
            2'b10:   return 18;
            default: return 34;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] make_word(input logic [WORD_W-1:0] s,
                                                    input logic [1:0] fmt,
                                                    input logic sg);
        logic [WORD_W-1:0] d;
        int w;
        w = width_of(fmt);
        d = {1'b0, s[DATA_W-1:0]} >> (DATA_W - w);
        if (sg) d = d | ({{(WORD_W-1){1'b0}}, s[WORD_W-1]} << w);
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] orient(input logic [WORD_W-1:0] word,
                                                 input int len,
                                                 input logic lsb);
        logic [WORD_W-1:0] r;
        if (!lsb) begin
            r = word << (WORD_W - len);
        end else begin
            for (int i = 0; i < WORD_W; i++) r[WORD_W-1-i] = word[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_rsp_shift.sv
module adc_rsp_shift
    import adc_rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di,
    input  logic [WORD_W-1:0] load_img,
    output logic              do_o,
    output logic              xfer_start,
    output logic              instr_valid,
    output logic [7:0]        instr
);

    typedef struct packed {
        logic [2:0]        cs_sy;
        logic [2:0]        ck_sy;
        logic [1:0]        di_sy;
        logic              active;
        logic [3:0]        bitcnt;
        logic [7:0]        ish;
        logic [WORD_W-1:0] osh;
        logic              ivalid;
        logic              istart;
    } sh_t;

    sh_t q, d;
    logic cs_fall, cs_rise, ck_rise, ck_fall;

    always_comb begin
        d       = q;
        d.cs_sy = {q.cs_sy[1:0], cs_n};
        d.ck_sy = {q.ck_sy[1:0], sclk};
        d.di_sy = {q.di_sy[0], di};
        cs_fall = q.cs_sy[2] & ~q.cs_sy[1];
        cs_rise = ~q.cs_sy[2] & q.cs_sy[1];
        ck_rise = ~q.ck_sy[2] & q.ck_sy[1];
        ck_fall = q.ck_sy[2] & ~q.ck_sy[1];
        d.ivalid = 1'b0;
        d.istart = 1'b0;
        if (cs_fall) begin
            d.active = 1'b1;
            d.bitcnt = '0;
            d.osh    = load_img;
            d.istart = 1'b1;
        end else if (cs_rise) begin
            d.active = 1'b0;
        end else if (q.active) begin
            if (ck_rise && q.bitcnt < 4'd8) begin
                d.ish    = {q.ish[6:0], q.di_sy[1]};
                d.bitcnt = q.bitcnt + 4'd1;
                if (q.bitcnt == 4'd7) d.ivalid = 1'b1;
            end
            if (ck_fall) d.osh = q.osh << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_sy <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign do_o        = q.active & q.osh[WORD_W-1];
    assign xfer_start  = q.istart;
    assign instr_valid = q.ivalid;
    assign instr       = q.ish;

    AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitcnt <= 4'd8); // R2
    AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (q.active && q.osh == $past(load_img))); // R11

endmodule

// File: rtl/adc_rsp_ctrl.sv
module adc_rsp_ctrl
    import adc_rsp_pkg::*;
#(
    parameter int CAL_CYCLES   = 600,
    parameter int CONV_CYCLES  = 40,
    parameter int PWRUP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              instr_valid,
    input  logic [7:0]        instr,
    input  logic [WORD_W-1:0] sample,
    output logic [WORD_W-1:0] load_img,
    output logic              eoc
);

    localparam int CAW = $clog2(CAL_CYCLES + 1);
    localparam int CVW = $clog2(CONV_CYCLES + 34 + 1);
    localparam int PUW = $clog2(PWRUP_CYCLES + 1);

    typedef struct packed {
        logic [1:0]        fmt;
        logic              sgn;
        logic              lsb;
        logic [1:0]        acq;
        logic              armed;
        logic              sts_sel;
        logic              pu_busy;
        logic [PUW-1:0]    pu_cnt;
        logic              cal_busy;
        logic [CAW-1:0]    cal_cnt;
        logic              conv_busy;
        logic [CVW-1:0]    conv_cnt;
        logic [1:0]        c_fmt;
        logic              c_sgn;
        logic              c_lsb;
        logic [WORD_W-1:0] res_img;
    } ct_t;

    ct_t q, d;
    logic [2:0] op;
    logic [8:0] status;

    assign op = instr[7:5];

    always_comb begin
        d = q;
        if (q.pu_busy) begin
            if (q.pu_cnt == '0) d.pu_busy = 1'b0;
            else                d.pu_cnt  = q.pu_cnt - 1'b1;
        end
        if (q.cal_busy) begin
            if (q.cal_cnt == '0) d.cal_busy = 1'b0;
            else                 d.cal_cnt  = q.cal_cnt - 1'b1;
        end
        if (q.conv_busy) begin
            if (q.conv_cnt == '0) begin
                d.conv_busy = 1'b0;
                d.res_img   = orient(make_word(sample, q.c_fmt, q.c_sgn),
                                     width_of(q.c_fmt) + int'(q.c_sgn), q.c_lsb);
            end else begin
                d.conv_cnt = q.conv_cnt - 1'b1;
            end
        end
        if (xfer_start && q.conv_busy) d.conv_busy = 1'b0;
        if (instr_valid) begin
            if (!q.armed) begin
                d.armed    = 1'b1;
                d.cal_busy = 1'b1;
                d.cal_cnt  = CAW'(CAL_CYCLES - 1);
            end else begin
                d.sts_sel = (op == OP_STATUS);
                case (op)
                    OP_SIGN: d.sgn = instr[0];
                    OP_ACQ:  d.acq = instr[1:0];
                    OP_CONV: begin
                        if (!q.cal_busy) begin
                            d.fmt       = instr[1:0];
                            d.lsb       = instr[2];
                            d.c_fmt     = instr[1:0];
                            d.c_lsb     = instr[2];
                            d.c_sgn     = q.sgn;
                            d.conv_busy = 1'b1;
                            d.conv_cnt  = CVW'(acq_of(q.acq) + CONV_CYCLES - 1);
                        end
                    end
                    OP_CAL: begin
                        d.cal_busy = 1'b1;
                        d.cal_cnt  = CAW'(CAL_CYCLES - 1);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.fmt     <= 2'b01;
            q.sgn     <= 1'b1;
            q.acq     <= 2'b01;
            q.pu_busy <= 1'b1;
            q.pu_cnt  <= PUW'(PWRUP_CYCLES - 1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status = {1'b0, q.lsb, q.sgn, q.fmt[1], (q.fmt == 2'b01), (q.fmt == 2'b00),
                  q.cal_busy, 1'b0, q.pu_busy};
        if (q.sts_sel)       load_img = {status, 8'b0};
        else if (q.cal_busy) load_img = '0;
        else                 load_img = q.res_img;
    end

    assign eoc = ~q.conv_busy;

    AST_CAL_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !q.armed) |=> q.cal_busy); // R3
    AST_NO_CONV_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.conv_busy && q.cal_busy)); // R10
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && q.conv_busy) |=> (!q.conv_busy && $stable(q.res_img))); // R9
    AST_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && q.armed && (op == OP_SIGN || op == OP_ACQ))
        |=> (!q.conv_busy && $stable(q.res_img))); // R8

endmodule

// File: rtl/adc_rsp.sv
module adc_rsp
    import adc_rsp_pkg::*;
#(
    parameter int CAL_CYCLES   = 600,
    parameter int CONV_CYCLES  = 40,
    parameter int PWRUP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di,
    input  logic [WORD_W-1:0] sample,
    output logic              do_o,
    output logic              eoc
);

    logic              xfer_start;
    logic              instr_valid;
    logic [7:0]        instr;
    logic [WORD_W-1:0] load_img;

    adc_rsp_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .di          (di),
        .load_img    (load_img),
        .do_o        (do_o),
        .xfer_start  (xfer_start),
        .instr_valid (instr_valid),
        .instr       (instr)
    );

    adc_rsp_ctrl #(
        .CAL_CYCLES   (CAL_CYCLES),
        .CONV_CYCLES  (CONV_CYCLES),
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_start  (xfer_start),
        .instr_valid (instr_valid),
        .instr       (instr),
        .sample      (sample),
        .load_img    (load_img),
        .eoc         (eoc)
    );

endmodule

// File: tb/sim_adc_rsp.sv
`timescale 1ns/1ps
module sim_adc_rsp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        di = 1'b0;
    logic [16:0] sample = '0;
    logic        do_o;
    logic        eoc;

    int checks = 0;
    int errors = 0;
    int run = 0;
    int last_run = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_rsp u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
        .di (di), .sample (sample), .do_o (do_o), .eoc (eoc)
    );

    always @(negedge clk) begin
        if (rst_n && eoc == 1'b0) run <= run + 1;
        else if (run != 0) begin
            last_run <= run;
            run      <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] ins, input int nbits, input bit lsb,
                        output logic [16:0] w);
        w = '0;
        cs_n = 1'b0;
        idle(4);
        for (int i = 0; i < nbits; i++) begin
            di = (i < 8) ? ins[7-i] : 1'b0;
            idle(4);
            if (lsb) w[i] = do_o;
            else     w = {w[15:0], do_o};
            sclk = 1'b1;
            idle(4);
            sclk = 1'b0;
        end
        idle(4);
        cs_n = 1'b1;
        di   = 1'b0;
        idle(8);
    endtask

    task automatic wait_eoc();
        for (int i = 0; i < 2000 && eoc == 1'b0; i++) idle(1);
        idle(2);
    endtask

    task automatic t_reset();
        idle(2);
        chk(eoc == 1'b1, "R1 eoc after reset", int'(eoc), 1);
        chk(do_o == 1'b0, "R11 do idle", int'(do_o), 0);
    endtask

    task automatic t_calibration();
        logic [16:0] w;
        idle(40);
        xfer(8'h60, 13, 1'b0, w);      // first instruction: starts calibration (R3)
        xfer(8'h60, 13, 1'b0, w);      // R3: zeros during calibration
        chk(w == 17'h0, "R3 zero word in calibration", int'(w), 0);
        xfer(8'h60, 9, 1'b0, w);       // R4: status while calibrating
        chk(w == 17'h054, "R4 status busy", int'(w), 'h054);
        chk(do_o == 1'b0, "R11 do low between transfers", int'(do_o), 0);
        idle(700);
        xfer(8'h40, 9, 1'b0, w);       // R4/R1: idle status, defaults
        chk(w == 17'h050, "R1 R4 status idle defaults", int'(w), 'h050);
    endtask

    task automatic t_conv_signed();
        logic [16:0] w;
        sample = 17'h1A5C3;
        chk(eoc == 1'b0, "R5 eoc low during conversion", int'(eoc), 0);
        wait_eoc();
        chk(last_run == 50, "R5 R6 conversion length acq 10", last_run, 50);
        xfer(8'h00, 9, 1'b0, w);       // sign off, R7: 8-bit plus sign MSB first
        chk(w == 17'h1A5, "R7 signed 8-bit word", int'(w), 'h1A5);
        idle(20);
        chk(eoc == 1'b1, "R8 sign config no conversion", int'(eoc), 1);
        xfer(8'h20, 9, 1'b0, w);       // acquisition select 00
        chk(w == 17'h1A5, "R8 result repeated", int'(w), 'h1A5);
        chk(eoc == 1'b1, "R8 acq config no conversion", int'(eoc), 1);
    endtask

    task automatic t_conv_lsb();
        logic [16:0] w;
        sample = 17'h01234;
        xfer(8'h46, 9, 1'b0, w);       // convert 16-bit LSB first
        chk(w == 17'h1A5, "R8 result after configs", int'(w), 'h1A5);
        wait_eoc();
        chk(last_run == 46, "R6 conversion length acq 6", last_run, 46);
        xfer(8'h60, 16, 1'b1, w);
        chk(w == 17'h1234, "R7 unsigned 16-bit LSB first", int'(w), 'h1234);
        xfer(8'h41, 9, 1'b0, w);       // status; starts 12-bit MSB conversion
        chk(w == 17'h0A0, "R4 status 16-bit lsb no sign", int'(w), 'h0A0);
    endtask

    task automatic t_abort();
        logic [16:0] w;
        sample = 17'h0FFFF;
        chk(eoc == 1'b0, "R9 conversion running", int'(eoc), 0);
        xfer(8'hE0, 16, 1'b1, w);
        chk(eoc == 1'b1, "R9 eoc after abort", int'(eoc), 1);
        chk(last_run < 46, "R9 conversion cut short", last_run, 45);
        chk(w == 17'h1234, "R9 old result shifted", int'(w), 'h1234);
        idle(100);
        xfer(8'h80, 16, 1'b1, w);      // start calibration
        chk(w == 17'h1234, "R9 result not loaded", int'(w), 'h1234);
    endtask

    task automatic t_conv_in_cal();
        logic [16:0] w;
        xfer(8'h42, 16, 1'b1, w);      // convert during calibration: ignored
        chk(w == 17'h0, "R3 zeros during recalibration", int'(w), 0);
        idle(60);
        chk(eoc == 1'b1, "R10 convert ignored in calibration", int'(eoc), 1);
        idle(700);
        xfer(8'h60, 16, 1'b1, w);
        chk(w == 17'h1234, "R10 result unchanged", int'(w), 'h1234);
        xfer(8'hE0, 9, 1'b0, w);
        chk(w == 17'h010, "R4 R10 status 12-bit msb", int'(w), 'h010);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_calibration();
        t_conv_signed();
        t_conv_lsb();
        t_abort();
        t_conv_in_cal();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule